// File: doc/BRIEF.md
# I2C SCL and Condition Generator

This block turns a fast system clock into the serial clock of an I2C master and places START, repeated START and STOP conditions on the bus when asked. Two programmable counts set the shape of the SCL waveform. Each count unit is stretched over eight equal sub-phases, so the low part lasts `8*(div_lo+1)` system clocks and the high part lasts `8*(div_hi+1)` system clocks. The outputs are open-drain pull-down enables: a 1 on `scl_oe` or `sda_oe` pulls that line low, and a 0 releases it to the pull-up.

A transfer engine beside this block issues single-cycle `start_req` and `stop_req` strobes. Once a START is complete the block keeps SCL running, with SDA held low between conditions. Each finished condition sets its own sticky pending flag, and software clears a flag by writing a 1 to its bit. Dropping `enable` puts the block straight back to the released idle state. Slave clock stretching and arbitration between masters are not handled.

Top module: `scl_cond_gen`

## Requirements
- R1: While SCL runs, each low part lasts exactly 8*(div_lo+1) cycles and each high part lasts exactly 8*(div_hi+1) cycles.
- R2: A `start_req` in idle with `enable`=1 sets `sda_oe`=1 one cycle later while `scl_oe` stays 0. `scl_oe` then rises 4*(div_hi+1) cycles after `sda_oe` rose.
- R3: `pend_start` becomes 1 in the same cycle that `scl_oe` rises at the end of a START or repeated START.
- R4: A `stop_req` that arrives before the middle of an SCL low part is carried out at the end of that low part. `scl_oe` falls, and 4*(div_hi+1) cycles later `sda_oe` falls. In that same cycle `pend_stop` becomes 1, and the block is then idle with both lines released.
- R5: While `scl_oe` stays 1, `sda_oe` changes only 4*(div_lo+1) cycles after the rise of `scl_oe`.
- R6: A `start_req` while SCL runs gives a repeated START. `sda_oe` falls in the middle of the low part and `scl_oe` falls at its end. `sda_oe` rises 4*(div_hi+1) cycles later, and `scl_oe` rises a further 4*(div_hi+1) cycles after that.
- R7: A cycle with `clr_we`=1 clears each pending flag whose `clr_mask` bit is 1 (bit 0 is the start flag, bit 1 is the stop flag) and leaves the other flag unchanged. With `clr_we`=0 the mask has no effect.
- R8: `enable`=0 releases both lines by the next cycle and ignores requests. The pending flags are kept.
- R9: A `stop_req` in idle is ignored: the lines stay released and `pend_stop` stays 0.
- R10: After reset both lines are released and both pending flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; 0 forces idle |
| div_lo | input | DIV_W | Low-part count (unit = 8 sub-phases) |
| div_hi | input | DIV_W | High-part count (unit = 8 sub-phases) |
| start_req | input | 1 | One-cycle START / repeated START request |
| stop_req | input | 1 | One-cycle STOP request |
| clr_we | input | 1 | Write strobe for flag clearing |
| clr_mask | input | 2 | Write-one-to-clear mask: bit 0 start, bit 1 stop |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| pend_start | output | 1 | Sticky START-complete flag |
| pend_stop | output | 1 | Sticky STOP-complete flag |

## Verification
A wrong sub-phase count or a wrong divisor choice shows up in the first SCL edge after the fault as a low or high width that is off, so it is caught within one SCL period. A corrupted pending action shows at the next mid-low point: SDA moves when it should not, or fails to move before the high part. A missing flag set or a leaky clear shows at the pending outputs in the cycle the condition ends, or the cycle after the clear. Random divisor pairs, including the smallest, drive both STOP and repeated-START paths, so each timing relation is measured against several divisor values.

// File: rtl/scl_cond_gen_pkg.sv
package scl_cond_gen_pkg;
   typedef enum logic [2:0] {
      CG_IDLE,
      CG_START,
      CG_LOW,
      CG_HIGH,
      CG_RS_HI,
      CG_STOP_HI
   } cg_state_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_RESTART,
      OP_STOP
   } cg_op_e;

   localparam int NUM_FLAGS = 2;
   localparam int FLAG_START = 0;
   localparam int FLAG_STOP = 1;
endpackage

// File: rtl/cg_phase_timer.sv
module cg_phase_timer #(
   parameter int DIV_W = 8,
   parameter int SUB_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             use_hi,
   input  logic [DIV_W-1:0] div_lo,
   input  logic [DIV_W-1:0] div_hi,
   output logic             tick,
   output logic [SUB_W-1:0] sub
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] div_cur;

   assign div_cur = use_hi ? div_hi : div_lo;
   assign tick    = run && (cnt >= div_cur);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         sub <= '0;
      end else if (!run || restart) begin
         cnt <= '0;
         sub <= '0;
      end else if (tick) begin
         cnt <= '0;
         sub <= sub + 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/cg_ctrl_fsm.sv
module cg_ctrl_fsm
   import scl_cond_gen_pkg::*;
#(
   parameter int SUB_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             tick,
   input  logic [SUB_W-1:0] sub,
   output logic             run,
   output logic             restart,
   output logic             use_hi,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             set_start,
   output logic             set_stop
);
   localparam logic [SUB_W-1:0] HALF_LAST = SUB_W'((1 << (SUB_W - 1)) - 1);
   localparam logic [SUB_W-1:0] FULL_LAST = '1;

   cg_state_e state, state_n;
   cg_op_e    op, op_n, act;
   logic      half_done, full_done;

   assign half_done = tick && (sub == HALF_LAST);
   assign full_done = tick && (sub == FULL_LAST);

   always_comb begin
      state_n   = state;
      set_start = 1'b0;
      set_stop  = 1'b0;
      unique case (state)
         CG_IDLE:    if (start_req) state_n = CG_START;
         CG_START:   if (half_done) begin
                        state_n   = CG_LOW;
                        set_start = 1'b1;
                     end
         CG_LOW:     if (full_done) begin
                        if (act == OP_STOP)         state_n = CG_STOP_HI;
                        else if (act == OP_RESTART) state_n = CG_RS_HI;
                        else                        state_n = CG_HIGH;
                     end
         CG_HIGH:    if (full_done) state_n = CG_LOW;
         CG_RS_HI:   if (half_done) state_n = CG_START;
         CG_STOP_HI: if (half_done) begin
                        state_n  = CG_IDLE;
                        set_stop = 1'b1;
                     end
         default:    state_n = CG_IDLE;
      endcase
      if (!enable) begin
         state_n   = CG_IDLE;
         set_start = 1'b0;
         set_stop  = 1'b0;
      end
   end

   // pending request: stop outranks start; consumed at the mid-low point
   always_comb begin
      op_n = op;
      if (state == CG_LOW && half_done) op_n = OP_NONE;
      if (stop_req)                                op_n = OP_STOP;
      else if (start_req && op_n != OP_STOP)       op_n = OP_RESTART;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= CG_IDLE;
         op    <= OP_NONE;
         act   <= OP_NONE;
      end else begin
         state <= state_n;
         if (!enable || state == CG_IDLE) op <= OP_NONE;
         else                             op <= op_n;
         if (state != CG_LOW)  act <= OP_NONE;
         else if (half_done)   act <= op;
      end
   end

   assign run     = (state != CG_IDLE);
   assign restart = (state_n != state);
   assign use_hi  = (state != CG_LOW);
   assign scl_oe  = (state == CG_LOW);

   always_comb begin
      unique case (state)
         CG_START, CG_HIGH, CG_STOP_HI: sda_oe = 1'b1;
         CG_LOW:                        sda_oe = (act != OP_RESTART);
         default:                       sda_oe = 1'b0;
      endcase
   end
endmodule

// File: rtl/cg_pend_flags.sv
module cg_pend_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_we,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)                       flags[i] <= 1'b0;
         else if (set[i])                  flags[i] <= 1'b1;
         else if (clr_we && clr_mask[i])   flags[i] <= 1'b0;
      end

      assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags[i]);
      assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && clr_mask[i] && !set[i]) |=> !flags[i]);
      assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_we && !set[i]) |=> $stable(flags[i]));
   end
endmodule

// File: rtl/scl_cond_gen.sv
module scl_cond_gen
   import scl_cond_gen_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int SUB_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [DIV_W-1:0] div_lo,
   input  logic [DIV_W-1:0] div_hi,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             clr_we,
   input  logic [1:0]       clr_mask,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             pend_start,
   output logic             pend_stop
);
   localparam logic [SUB_W-1:0] MID_SUB = SUB_W'(1 << (SUB_W - 1));

   if (DIV_W < 1 || DIV_W > 24) begin : g_bad_div_w
      $error("scl_cond_gen: DIV_W must lie in 1..24");
   end
   if (SUB_W != 3) begin : g_bad_sub_w
      $error("scl_cond_gen: SUB_W must be 3 (eight sub-phases per unit)");
   end

   logic             run, restart, use_hi, tick;
   logic [SUB_W-1:0] sub;
   logic             set_start, set_stop;
   logic [NUM_FLAGS-1:0] set_vec, flag_vec;

   cg_phase_timer #(.DIV_W(DIV_W), .SUB_W(SUB_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (restart),
      .use_hi  (use_hi),
      .div_lo  (div_lo),
      .div_hi  (div_hi),
      .tick    (tick),
      .sub     (sub)
   );

   cg_ctrl_fsm #(.SUB_W(SUB_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .start_req (start_req),
      .stop_req  (stop_req),
      .tick      (tick),
      .sub       (sub),
      .run       (run),
      .restart   (restart),
      .use_hi    (use_hi),
      .scl_oe    (scl_oe),
      .sda_oe    (sda_oe),
      .set_start (set_start),
      .set_stop  (set_stop)
   );

   always_comb begin
      set_vec             = '0;
      set_vec[FLAG_START] = set_start;
      set_vec[FLAG_STOP]  = set_stop;
   end

   cg_pend_flags #(.N(NUM_FLAGS)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (set_vec),
      .clr_we   (clr_we),
      .clr_mask (clr_mask),
      .flags    (flag_vec)
   );

   assign pend_start = flag_vec[FLAG_START];
   assign pend_stop  = flag_vec[FLAG_STOP];

   assert_scl_edge_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scl_oe) |-> ($past(tick) || !$past(enable)));
   assert_start_flag_with_scl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_start) |-> scl_oe);
   assert_stop_flag_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_stop) |-> (!scl_oe && !sda_oe && $past(sda_oe)));
   assert_sda_mid_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe && $past(scl_oe) && !$stable(sda_oe)) |-> (sub == MID_SUB));
   assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_oe && !sda_oe));
endmodule

// File: tb/tb_scl_cond_gen.sv
module tb_scl_cond_gen;
   localparam int DIV_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic [DIV_W-1:0] div_lo = '0;
   logic [DIV_W-1:0] div_hi = '0;
   logic             start_req = 1'b0;
   logic             stop_req = 1'b0;
   logic             clr_we = 1'b0;
   logic [1:0]       clr_mask = '0;
   logic             scl_oe, sda_oe, pend_start, pend_stop;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int cur_l = 0;
   int cur_h = 0;
   bit finished = 1'b0;

   scl_cond_gen #(.DIV_W(DIV_W)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .div_lo(div_lo), .div_hi(div_hi),
      .start_req(start_req), .stop_req(stop_req), .clr_we(clr_we), .clr_mask(clr_mask),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .pend_start(pend_start), .pend_stop(pend_stop)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R5 monitor: SDA may only move at the middle of a held-low SCL part
   logic prev_scl = 1'b0, prev_sda = 1'b0;
   int   lo_t = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_oe && !prev_scl) lo_t = cyc;
         if (scl_oe && prev_scl && sda_oe != prev_sda)
            chk(cyc - lo_t == 4 * (cur_l + 1), "R5 sda move offset", cyc - lo_t, 4 * (cur_l + 1));
      end
      prev_scl = scl_oe;
      prev_sda = sda_oe;
   end

   task automatic wait_scl(input logic v, output int t);
      int n = 0;
      while (scl_oe !== v && n < 3000) begin @(negedge clk); n++; end
      if (n >= 3000) chk(1'b0, "timeout scl", int'(scl_oe), int'(v));
      t = cyc;
   endtask

   task automatic wait_sda(input logic v, output int t);
      int n = 0;
      while (sda_oe !== v && n < 3000) begin @(negedge clk); n++; end
      if (n >= 3000) chk(1'b0, "timeout sda", int'(sda_oe), int'(v));
      t = cyc;
   endtask

   task automatic pulse_start(); start_req = 1'b1; @(negedge clk); start_req = 1'b0; endtask
   task automatic pulse_stop();  stop_req  = 1'b1; @(negedge clk); stop_req  = 1'b0; endtask
   task automatic pulse_clr(input logic [1:0] m);
      clr_we = 1'b1; clr_mask = m; @(negedge clk); clr_we = 1'b0; clr_mask = '0;
   endtask

   function automatic int half_hi(); return 4 * (cur_h + 1); endfunction
   function automatic int full_lo(); return 8 * (cur_l + 1); endfunction
   function automatic int full_hi(); return 8 * (cur_h + 1); endfunction

   task automatic do_stop(input int t_low);
      int ts, tr;
      pulse_stop();
      wait_scl(1'b0, ts);
      chk(ts - t_low == full_lo(), "R4 scl release time", ts - t_low, full_lo());
      chk(sda_oe == 1'b1, "R4 sda held while scl rises", int'(sda_oe), 1);
      wait_sda(1'b0, tr);
      chk(tr - ts == half_hi(), "R4 sda release time", tr - ts, half_hi());
      chk(pend_stop == 1'b1, "R4 stop flag", int'(pend_stop), 1);
      chk(scl_oe == 1'b0, "R4 scl released at stop", int'(scl_oe), 0);
   endtask

   task automatic do_start(output int t1);
      int t0;
      pulse_start();
      t0 = cyc;
      chk(sda_oe == 1'b1 && scl_oe == 1'b0, "R2 sda low with scl high", int'({scl_oe, sda_oe}), 1);
      wait_scl(1'b1, t1);
      chk(t1 - t0 == half_hi(), "R2 start hold", t1 - t0, half_hi());
      chk(pend_start == 1'b1, "R3 start flag", int'(pend_start), 1);
   endtask

   task automatic trial(input int l, input int h, input bit rs);
      int t1, t2, t3, ta, tb, tc;
      cur_l = l; cur_h = h;
      div_lo = DIV_W'(l); div_hi = DIV_W'(h);
      pulse_clr(2'b11);
      do_start(t1);
      wait_scl(1'b0, t2);
      chk(t2 - t1 == full_lo(), "R1 low width", t2 - t1, full_lo());
      wait_scl(1'b1, t3);
      chk(t3 - t2 == full_hi(), "R1 high width", t3 - t2, full_hi());
      if (rs) begin
         pulse_clr(2'b01);
         chk(pend_start == 1'b0, "R7 clear start flag", int'(pend_start), 0);
         pulse_start();
         wait_scl(1'b0, ta);
         chk(ta - t3 == full_lo(), "R6 scl release time", ta - t3, full_lo());
         chk(sda_oe == 1'b0, "R6 sda released before scl", int'(sda_oe), 0);
         wait_sda(1'b1, tb);
         chk(tb - ta == half_hi(), "R6 sda fall time", tb - ta, half_hi());
         chk(scl_oe == 1'b0, "R6 scl high at start", int'(scl_oe), 0);
         wait_scl(1'b1, tc);
         chk(tc - tb == half_hi(), "R6 scl low time", tc - tb, half_hi());
         chk(pend_start == 1'b1, "R6 R3 start flag again", int'(pend_start), 1);
         do_stop(tc);
      end else begin
         do_stop(t3);
      end
      repeat (5) @(negedge clk);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R4 idle after stop", int'({scl_oe, sda_oe}), 0);
   endtask

   initial begin
      int t1;
      void'($urandom(32'd24681357));
      repeat (3) @(negedge clk);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R10 lines released", int'({scl_oe, sda_oe}), 0);
      chk(pend_start == 1'b0 && pend_stop == 1'b0, "R10 flags clear", int'({pend_stop, pend_start}), 0);
      rst_n = 1'b1;
      enable = 1'b1;
      @(negedge clk);

      trial(0, 0, 1'b0);
      trial(0, 0, 1'b1);
      trial(7, 2, 1'b1);
      for (int i = 0; i < 10; i++)
         trial(int'($urandom_range(7, 0)), int'($urandom_range(7, 0)), i[0]);

      // R7: both flags set, then selective and full clears
      cur_l = 0; cur_h = 0; div_lo = '0; div_hi = '0;
      trial(0, 0, 1'b0);
      chk(pend_start == 1'b1 && pend_stop == 1'b1, "R7 both flags set", int'({pend_stop, pend_start}), 3);
      clr_mask = 2'b11; @(negedge clk); clr_mask = '0;
      chk(pend_start == 1'b1 && pend_stop == 1'b1, "R7 mask without strobe", int'({pend_stop, pend_start}), 3);
      pulse_clr(2'b01);
      chk(pend_start == 1'b0 && pend_stop == 1'b1, "R7 clear start only", int'({pend_stop, pend_start}), 2);
      pulse_clr(2'b11);
      chk(pend_start == 1'b0 && pend_stop == 1'b0, "R7 clear all", int'({pend_stop, pend_start}), 0);

      // R9: stop in idle
      pulse_stop();
      repeat (40) @(negedge clk);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R9 lines stay released", int'({scl_oe, sda_oe}), 0);
      chk(pend_stop == 1'b0 && pend_start == 1'b0, "R9 no flag", int'({pend_stop, pend_start}), 0);

      // R8: disable while running
      cur_l = 3; cur_h = 1; div_lo = 8'd3; div_hi = 8'd1;
      do_start(t1);
      repeat (3) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R8 released after disable", int'({scl_oe, sda_oe}), 0);
      chk(pend_start == 1'b1, "R8 flag kept", int'(pend_start), 1);
      pulse_start();
      repeat (40) @(negedge clk);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R8 request ignored", int'({scl_oe, sda_oe}), 0);
      enable = 1'b1;
      pulse_clr(2'b11);
      trial(1, 3, 1'b0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule